// File: doc/BRIEF.md
# Receive Packet Status Queue

This block sits between a receive MAC and a host reader and keeps the per-packet receive status for packets that have arrived but not yet been consumed. The MAC announces a packet with a start strobe, drives a running byte count while the packet arrives, and closes it with an end strobe and a 4-bit error code. Each closed packet becomes one queue entry holding its byte count and normalised error code. The payload itself is not stored here.

The host always sees a 16-bit status word. If at least one completed packet is queued, the word describes the oldest one. If no completed packet is queued, bit 15 is set to mark the head as incomplete or absent, and the low bits show the running count of a packet still arriving.

The host removes the head entry with a discard strobe. When eight entries are held, a status-overrun flag rises and new packets are refused whole. The condition clears by itself once an entry is removed. A receive-reset strobe empties everything.

Top module: `rx_status_queue`

## Requirements
- R1: After `rst_n` is released, `host_status` is 16'h8000 and `rx_busy` and `stat_ovr` are both 0.
- R2: With no entry queued and no packet arriving, `host_status` is 16'h8000.
- R3: With no entry queued and a packet arriving, `host_status` has bit 15 set, bits 14..11 zero, and bits 10..0 equal to the byte count sampled on the previous clock.
- R4: With an entry queued, `host_status` has bit 15 clear, the entry's error code in bits 14..11 and its byte count in bits 10..0. Bit 14 is set exactly when the code is an error.
- R5: The end-of-packet code is stored unchanged when it is 1000 (overrun), 1001 (oversize), 1011 (runt), 1100 (alignment), 1101 (CRC) or 0010 (dribble bits). Any other code is stored as 0000.
- R6: A byte count above 1514 is reported as 1514, and that packet's code is forced to 1001 whatever code the MAC gave.
- R7: Entries leave in the order their packets ended, and the queue holds up to eight.
- R8: `stat_ovr` is 1 exactly while eight entries are held. While it is 1, a start strobe is ignored, and so is the end strobe of that refused packet.
- R9: When an entry is removed from a full queue, `stat_ovr` returns to 0 on the next cycle with no other host action, and the next start strobe is accepted.
- R10: `host_discard` removes the head entry. With no entry queued it has no effect, and it does not disturb a packet that is arriving.
- R11: `rx_busy` rises the cycle after an accepted start strobe and falls the cycle after the end strobe. A start strobe while busy and an end strobe while idle are ignored.
- R12: A `rx_reset` strobe empties the queue, abandons any arriving packet and clears both flags on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_reset | input | 1 | Synchronous receive-reset strobe |
| mac_sop | input | 1 | Start of packet from the MAC |
| mac_count | input | 11 | Running byte count of the arriving packet |
| mac_eop | input | 1 | End of packet from the MAC |
| mac_err | input | 4 | Error code, valid with `mac_eop` |
| host_discard | input | 1 | Remove the head entry |
| host_status | output | 16 | Status word of the head packet |
| rx_busy | output | 1 | A packet is being received |
| stat_ovr | output | 1 | Eight entries held, new packets refused |

## Verification
The assertions watch these properties on every cycle:
- the status fields stay inside their legal ranges;
- the in-progress word carries no error code;
- a full queue never coexists with an arriving packet;
- a start strobe against a full queue never raises `rx_busy`;
- a removal always clears the overrun flag;
- a receive reset always yields the empty state.

Only the bench's scenarios can show the following:
- FIFO ordering across eight entries;
- the exact code normalisation and saturation for each code;
- that a refused packet leaves no trace;
- that an empty discard or a stray strobe changes nothing.

// File: rtl/rx_status_queue.sv
module rx_status_queue #(
  parameter int DEPTH     = 8,
  parameter int MAX_BYTES = 1514
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_reset,
  input  logic        mac_sop,
  input  logic [10:0] mac_count,
  input  logic        mac_eop,
  input  logic [3:0]  mac_err,
  input  logic        host_discard,
  output logic [15:0] host_status,
  output logic        rx_busy,
  output logic        stat_ovr
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OW = $clog2(DEPTH + 1);
  localparam logic [10:0]   CAP    = 11'(MAX_BYTES);
  localparam logic [PW-1:0] LAST   = PW'(DEPTH - 1);
  localparam logic [OW-1:0] FULL_N = OW'(DEPTH);

  logic [14:0]   slot [DEPTH];
  logic [PW-1:0] rd_p, wr_p;
  logic [OW-1:0] occ;
  logic [10:0]   run_cnt;
  logic          busy;
  logic          empty, full, open_pkt, close_pkt, pop;
  logic [10:0]   cnt_sat;
  logic [3:0]    code;

  assign empty     = (occ == '0);
  assign full      = (occ == FULL_N);
  assign open_pkt  = mac_sop && !busy && !full;
  assign close_pkt = mac_eop && busy;
  assign pop       = host_discard && !empty;
  assign cnt_sat   = (mac_count > CAP) ? CAP : mac_count;

  always_comb begin
    if (mac_count > CAP) code = 4'b1001;
    else begin
      case (mac_err)
        4'b1000, 4'b1001, 4'b1011, 4'b1100, 4'b1101, 4'b0010: code = mac_err;
        default: code = 4'b0000;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; run_cnt <= '0; rd_p <= '0; wr_p <= '0; occ <= '0;
    end else if (rx_reset) begin
      busy <= 1'b0; run_cnt <= '0; rd_p <= '0; wr_p <= '0; occ <= '0;
    end else begin
      if (open_pkt) begin
        busy    <= 1'b1;
        run_cnt <= cnt_sat;
      end else if (close_pkt) begin
        busy    <= 1'b0;
        run_cnt <= '0;
      end else if (busy) begin
        run_cnt <= cnt_sat;
      end
      if (close_pkt) wr_p <= (wr_p == LAST) ? '0 : wr_p + PW'(1);
      if (pop)       rd_p <= (rd_p == LAST) ? '0 : rd_p + PW'(1);
      occ <= occ + OW'(close_pkt) - OW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (close_pkt) slot[wr_p] <= {code, cnt_sat};
  end

  assign host_status = empty ? {1'b1, 4'b0000, run_cnt} : {1'b0, slot[rd_p]};
  assign rx_busy     = busy;
  assign stat_ovr    = full;
endmodule

// File: rtl/rx_status_queue_sva.sv
module rx_status_queue_sva #(
  parameter int MAX_BYTES = 1514
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_reset,
  input logic        mac_sop,
  input logic        host_discard,
  input logic [15:0] host_status,
  input logic        rx_busy,
  input logic        stat_ovr
);
  assert_inprog_no_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_status[15] |-> host_status[14:11] == 4'b0000);

  assert_code_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !host_status[15] |-> (host_status[14:11] inside {4'b0000, 4'b0010, 4'b1000,
                                                    4'b1001, 4'b1011, 4'b1100, 4'b1101}));

  assert_count_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_status[10:0] <= 11'(MAX_BYTES));

  assert_full_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stat_ovr |-> !rx_busy);

  assert_full_refuses_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ovr && mac_sop) |=> !rx_busy);

  assert_pop_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_ovr && host_discard) |=> !stat_ovr);

  assert_busy_needs_sop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_busy) |-> $past(mac_sop));

  assert_rx_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset |=> (host_status == 16'h8000 && !rx_busy && !stat_ovr));
endmodule

bind rx_status_queue rx_status_queue_sva #(.MAX_BYTES(MAX_BYTES)) u_sva (
  .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .mac_sop(mac_sop),
  .host_discard(host_discard), .host_status(host_status),
  .rx_busy(rx_busy), .stat_ovr(stat_ovr)
);

// File: tb/rx_status_queue_test.sv
module rx_status_queue_test;
  localparam int DEPTH = 8;
  localparam int MAXB  = 1514;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, rx_reset, mac_sop, mac_eop, host_discard;
  logic [10:0] mac_count;
  logic [3:0]  mac_err;
  logic [15:0] host_status;
  logic        rx_busy, stat_ovr;

  rx_status_queue #(.DEPTH(DEPTH), .MAX_BYTES(MAXB)) uut (
    .clk(clk), .rst_n(rst_n), .rx_reset(rx_reset), .mac_sop(mac_sop),
    .mac_count(mac_count), .mac_eop(mac_eop), .mac_err(mac_err),
    .host_discard(host_discard), .host_status(host_status),
    .rx_busy(rx_busy), .stat_ovr(stat_ovr)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int q[$];
  bit m_busy = 0;
  int m_cur  = 0;
  bit m_full, m_acc, m_cls, m_pop;

  function automatic int sat(int c);
    return (c > MAXB) ? MAXB : c;
  endfunction

  function automatic int enc(int c, int e);
    int k;
    if (c > MAXB) k = 9;
    else if (e inside {8, 9, 11, 12, 13, 2}) k = e;
    else k = 0;
    return (k << 11) | sat(c);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || rx_reset) begin
      q.delete(); m_busy = 0; m_cur = 0;
    end else begin
      m_full = (q.size() == DEPTH);
      m_acc  = mac_sop && !m_busy && !m_full;
      m_cls  = mac_eop && m_busy;
      m_pop  = host_discard && (q.size() > 0);
      if (m_pop) void'(q.pop_front());
      if (m_cls) begin
        q.push_back(enc(int'(mac_count), int'(mac_err)));
        m_busy = 0; m_cur = 0;
      end else if (m_acc) begin
        m_busy = 1; m_cur = sat(int'(mac_count));
      end else if (m_busy) begin
        m_cur = sat(int'(mac_count));
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic tick();
    int es;
    @(negedge clk);
    es = (q.size() > 0) ? q[0] : (32'h8000 | m_cur);
    chk((q.size() > 0) ? "R4 model status" : (m_busy ? "R3 model status" : "R2 model status"),
        int'(host_status), es);
    chk("R11 model busy", int'(rx_busy), int'(m_busy));
    chk("R8 model ovr", int'(stat_ovr), int'(q.size() == DEPTH));
  endtask

  task automatic pkt(int len, int code);
    mac_sop = 1; mac_count = 11'(0); tick();
    mac_sop = 0; mac_count = 11'(len / 2); tick();
    mac_eop = 1; mac_count = 11'(len); mac_err = 4'(code); tick();
    mac_eop = 0; mac_count = '0; mac_err = '0;
  endtask

  task automatic discard();
    host_discard = 1; tick(); host_discard = 0;
  endtask

  initial begin
    int exp_order[8];
    rst_n = 0; rx_reset = 0; mac_sop = 0; mac_eop = 0; host_discard = 0;
    mac_count = '0; mac_err = '0;
    tick(); tick(); tick();
    rst_n = 1; tick();
    chk("R1 reset status", int'(host_status), 16'h8000);
    chk("R1 reset busy", int'(rx_busy), 0);
    chk("R1 reset ovr", int'(stat_ovr), 0);
    tick();
    chk("R2 idle status", int'(host_status), 16'h8000);

    mac_sop = 1; mac_count = 11'(0); tick();
    chk("R11 busy after sop", int'(rx_busy), 1);
    mac_sop = 0; mac_count = 11'(40); tick();
    chk("R3 running count", int'(host_status), 16'h8028);
    mac_eop = 1; mac_count = 11'(64); mac_err = 4'b1101; tick();
    mac_eop = 0; mac_count = '0; mac_err = '0;
    chk("R4 CRC entry", int'(host_status), 16'h6840);
    chk("R11 busy after eop", int'(rx_busy), 0);

    discard();
    chk("R10 pop head", int'(host_status), 16'h8000);
    discard();
    chk("R10 empty pop ignored", int'(host_status), 16'h8000);

    mac_sop = 1; mac_count = 11'(0); tick();
    mac_sop = 0; mac_count = 11'(10); tick();
    host_discard = 1; tick(); host_discard = 0;
    chk("R10 pop during arrival busy", int'(rx_busy), 1);
    chk("R10 pop during arrival status", int'(host_status), 16'h800A);
    mac_eop = 1; mac_count = 11'(20); tick();
    mac_eop = 0; mac_count = '0;
    chk("R5 plain entry", int'(host_status), 16'h0014);
    discard();

    mac_sop = 1; mac_count = 11'(0); tick();
    mac_count = 11'(7); tick();
    mac_sop = 0; mac_eop = 1; mac_count = 11'(8); tick();
    mac_eop = 1; mac_count = 11'(99); tick();
    mac_eop = 0; mac_count = '0;
    chk("R11 stray eop ignored", int'(host_status), 16'h0008);
    discard();
    chk("R11 single entry only", int'(host_status), 16'h8000);

    pkt(100, 8); pkt(60, 11); pkt(70, 12); pkt(80, 13);
    pkt(200, 9); pkt(300, 2); pkt(1600, 0); pkt(50, 7);
    chk("R8 full flag", int'(stat_ovr), 1);
    chk("R7 head first", int'(host_status), 16'h4064);
    mac_sop = 1; tick(); mac_sop = 0;
    chk("R8 sop refused", int'(rx_busy), 0);
    mac_eop = 1; mac_count = 11'(77); tick(); mac_eop = 0; mac_count = '0;
    chk("R8 refused eop", int'(stat_ovr), 1);
    discard();
    chk("R9 auto clear", int'(stat_ovr), 0);
    pkt(33, 0);
    chk("R9 accepted again", int'(stat_ovr), 1);

    exp_order = '{16'h583C, 16'h6046, 16'h6850, 16'h48C8,
                  16'h112C, 16'h4DEA, 16'h0032, 16'h0021};
    for (int i = 0; i < 8; i++) begin
      case (i)
        3:       chk("R5 oversize code kept", int'(host_status), exp_order[i]);
        4:       chk("R5 dribble code kept", int'(host_status), exp_order[i]);
        5:       chk("R6 saturated count", int'(host_status), exp_order[i]);
        6:       chk("R5 unknown code dropped", int'(host_status), exp_order[i]);
        default: chk("R7 order", int'(host_status), exp_order[i]);
      endcase
      discard();
    end
    chk("R7 drained", int'(host_status), 16'h8000);

    pkt(10, 0); pkt(20, 8);
    mac_sop = 1; tick(); mac_sop = 0; mac_count = 11'(5); tick();
    rx_reset = 1; tick(); rx_reset = 0; mac_count = '0;
    chk("R12 status", int'(host_status), 16'h8000);
    chk("R12 busy", int'(rx_busy), 0);
    chk("R12 ovr", int'(stat_ovr), 0);
    tick();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule